// File: doc/BRIEF.md
# Effective Address Generator for an 8-bit CPU

This block turns an addressing-mode code and the operand bytes of an instruction into the 16-bit address that the instruction reads or writes. It is purely combinational. The CPU supplies the program counter of the opcode, the one or two bytes that follow it, and the X and Y index registers. In the same cycle the block returns the effective address and a flag that reports whether indexing carried into the high address byte. A sequencer can use that flag to insert the extra cycle that such a carry costs.

Three modes go through a 16-bit pointer held in memory: indexed indirect, indirect indexed and plain indirect. For these the block drives the addresses of the pointer's low and high bytes, and the surrounding memory returns the two bytes on the pointer data inputs in the same cycle.

Pointers in page zero wrap inside page zero. The plain indirect fetch takes the pointer's high byte from the same page as its low byte: when the low address byte is 0xFF, the next byte is taken from offset 0x00 of that page and no carry reaches the page byte. There are no streaming data, so no handshake is present, and every pin is a plain level.

Top module: `ea_gen`

## Requirements
- R1: Mode codes 0 (implied) and 1 (accumulator) give an effective address of 0x0000 with page_cross low.
- R2: Mode code 2 (immediate) gives the program counter plus one, modulo 65536.
- R3: Mode code 3 (zero page) gives {0x00, opnd_lo}.
- R4: Mode codes 4 (zero page,X) and 5 (zero page,Y) give {0x00, (opnd_lo + index) mod 256}, using X for code 4 and Y for code 5. The upper byte is always 0x00.
- R5: Mode code 6 (absolute) gives {opnd_hi, opnd_lo}.
- R6: Mode codes 7 (absolute,X) and 8 (absolute,Y) give ({opnd_hi, opnd_lo} + index) mod 65536. page_cross is high exactly when the result's upper byte differs from opnd_hi.
- R7: Mode code 9 (indexed indirect) drives the low pointer address {0x00, (opnd_lo + X) mod 256} and the high pointer address {0x00, (opnd_lo + X + 1) mod 256}. It gives {ptr_hi_data, ptr_lo_data}.
- R8: Mode code 10 (indirect indexed) drives the pointer addresses {0x00, opnd_lo} and {0x00, (opnd_lo + 1) mod 256}. It gives ({ptr_hi_data, ptr_lo_data} + Y) mod 65536, with page_cross high exactly when that sum's upper byte differs from ptr_hi_data.
- R9: Mode code 11 (indirect) drives the pointer addresses {opnd_hi, opnd_lo} and {opnd_hi, (opnd_lo + 1) mod 256}, with no carry into the page byte. It gives {ptr_hi_data, ptr_lo_data}.
- R10: Mode code 12 (relative) gives (pc + 2 + offset) mod 65536. The offset is opnd_lo taken as two's complement, so 0x80 to 0xFF are negative.
- R11: page_cross is low in every mode except codes 7, 8 and 10. Mode codes 13 to 15 give an effective address of 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode | input | 4 | Addressing-mode code |
| pc | input | 16 | Address of the opcode |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| ptr_lo_addr | output | 16 | Address of the pointer's low byte |
| ptr_hi_addr | output | 16 | Address of the pointer's high byte |
| ptr_lo_data | input | 8 | Byte read at ptr_lo_addr |
| ptr_hi_data | input | 8 | Byte read at ptr_hi_addr |
| ea | output | 16 | Effective address |
| page_cross | output | 1 | Indexing carried into the upper address byte |

## Verification
The assertions assume that the inputs have settled within the cycle. They also assume that the pointer data inputs are a pure function of the pointer addresses that the block drives. The bench keeps to both assumptions: it changes every input once per cycle, just after the rising edge, and it derives the pointer bytes from a fixed memory function of the driven addresses.

Directed vectors cover these cases:
- the page-zero wrap of pointers at 0xFF;
- the plain indirect fetch at a page end;
- indexing that carries and indexing that does not;
- the extremes of the relative offset;
- wrap at the ends of the address space;
- the unused mode codes.

Random vectors then cover all sixteen mode codes.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  typedef enum logic [3:0] {
    AM_IMPL = 4'd0,
    AM_ACC  = 4'd1,
    AM_IMM  = 4'd2,
    AM_ZP   = 4'd3,
    AM_ZPX  = 4'd4,
    AM_ZPY  = 4'd5,
    AM_ABS  = 4'd6,
    AM_ABSX = 4'd7,
    AM_ABSY = 4'd8,
    AM_INDX = 4'd9,
    AM_INDY = 4'd10,
    AM_IND  = 4'd11,
    AM_REL  = 4'd12
  } am_mode_e;
endpackage

// File: rtl/ea_ptr_addr.sv
module ea_ptr_addr
  import ea_gen_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  am_mode_e        mode,
  input  logic [DW-1:0]   opnd_lo,
  input  logic [DW-1:0]   opnd_hi,
  input  logic [DW-1:0]   idx_x,
  output logic [AW-1:0]   lo_addr,
  output logic [AW-1:0]   hi_addr
);
  logic [DW-1:0] page;
  logic [DW-1:0] off;
  logic [DW-1:0] off_next;

  always_comb begin
    page = '0;
    off  = '0;
    case (mode)
      AM_INDX: off = opnd_lo + idx_x;
      AM_INDY: off = opnd_lo;
      AM_IND: begin
        page = opnd_hi;
        off  = opnd_lo;
      end
      default: ;
    endcase
  end

  // The offset wraps inside its page; the page byte never takes a carry.
  assign off_next = off + DW'(1);
  assign lo_addr  = {page, off};
  assign hi_addr  = {page, off_next};

  always_comb begin
    // R9
    ptr_same_page_chk: assert (lo_addr[AW-1:DW] == hi_addr[AW-1:DW]);
    // R7
    ptr_zero_page_chk: assert (!(mode == AM_INDX || mode == AM_INDY) || hi_addr[AW-1:DW] == '0);
  end
endmodule

// File: rtl/ea_index_add.sv
module ea_index_add #(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] idx,
  output logic [AW-1:0] sum,
  output logic          crossed
);
  logic [DW:0]   low_sum;
  logic [DW-1:0] high_sum;

  assign low_sum  = {1'b0, base[DW-1:0]} + {1'b0, idx};
  assign high_sum = base[AW-1:DW] + DW'(low_sum[DW]);
  assign sum      = {high_sum, low_sum[DW-1:0]};
  assign crossed  = low_sum[DW];

  always_comb begin
    // R6
    cross_page_chk: assert (crossed == (sum[AW-1:DW] != base[AW-1:DW]));
  end
endmodule

// File: rtl/ea_rel_target.sv
module ea_rel_target #(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] offset,
  output logic [AW-1:0] target
);
  logic [AW-1:0] next_pc;
  logic [AW-1:0] sext;

  assign next_pc = pc + AW'(2);
  assign sext    = {{DW{offset[DW-1]}}, offset};
  assign target  = next_pc + sext;
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned AW = 2 * DW
) (
  input  logic [3:0]    mode,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] opnd_lo,
  input  logic [DW-1:0] opnd_hi,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  output logic [AW-1:0] ptr_lo_addr,
  output logic [AW-1:0] ptr_hi_addr,
  input  logic [DW-1:0] ptr_lo_data,
  input  logic [DW-1:0] ptr_hi_data,
  output logic [AW-1:0] ea,
  output logic          page_cross
);
  localparam int unsigned NADD = 2;

  am_mode_e      am;
  logic [AW-1:0] ptr_word;
  logic [AW-1:0] rel_ea;
  logic [DW-1:0] zp_off;
  logic [AW-1:0] add_base [NADD];
  logic [DW-1:0] add_idx  [NADD];
  logic [AW-1:0] add_sum  [NADD];
  logic          add_cross[NADD];

  assign am       = am_mode_e'(mode);
  assign ptr_word = {ptr_hi_data, ptr_lo_data};

  ea_ptr_addr #(.DW(DW)) u_ptr (
    .mode(am), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x),
    .lo_addr(ptr_lo_addr), .hi_addr(ptr_hi_addr)
  );

  ea_rel_target #(.DW(DW)) u_rel (
    .pc(pc), .offset(opnd_lo), .target(rel_ea)
  );

  // Adder 0 serves the absolute indexed modes; adder 1 the pointer plus Y.
  assign add_base[0] = {opnd_hi, opnd_lo};
  assign add_idx[0]  = (am == AM_ABSY) ? idx_y : idx_x;
  assign add_base[1] = ptr_word;
  assign add_idx[1]  = idx_y;

  for (genvar g = 0; g < NADD; g++) begin : g_add
    ea_index_add #(.DW(DW)) u_add (
      .base(add_base[g]), .idx(add_idx[g]),
      .sum(add_sum[g]), .crossed(add_cross[g])
    );
  end

  assign zp_off = opnd_lo + ((am == AM_ZPY) ? idx_y : idx_x);

  always_comb begin
    ea         = '0;
    page_cross = 1'b0;
    case (am)
      AM_IMM:  ea = pc + AW'(1);
      AM_ZP:   ea = {{DW{1'b0}}, opnd_lo};
      AM_ZPX,
      AM_ZPY:  ea = {{DW{1'b0}}, zp_off};
      AM_ABS:  ea = {opnd_hi, opnd_lo};
      AM_ABSX,
      AM_ABSY: begin
        ea         = add_sum[0];
        page_cross = add_cross[0];
      end
      AM_INDX,
      AM_IND:  ea = ptr_word;
      AM_INDY: begin
        ea         = add_sum[1];
        page_cross = add_cross[1];
      end
      AM_REL:  ea = rel_ea;
      default: ;
    endcase
  end

  always_comb begin
    // R11
    cross_mode_chk: assert (!page_cross || am == AM_ABSX || am == AM_ABSY || am == AM_INDY);
    // R4
    zp_result_chk: assert (!(am == AM_ZP || am == AM_ZPX || am == AM_ZPY) || ea[AW-1:DW] == '0);
    // R1
    no_addr_chk: assert (!(am == AM_IMPL || am == AM_ACC) || (ea == '0 && !page_cross));
  end
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  mode = 4'd0;
  logic [15:0] pc = 16'h0;
  logic [7:0]  opnd_lo = 8'h0, opnd_hi = 8'h0, idx_x = 8'h0, idx_y = 8'h0;
  logic [15:0] ptr_lo_addr, ptr_hi_addr, ea;
  logic [7:0]  ptr_lo_data, ptr_hi_data;
  logic        page_cross;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    int v;
    v = (int'(a) * 37 + (int'(a) >> 8) * 11) ^ 'h5A;
    return 8'(v);
  endfunction

  assign ptr_lo_data = mem_byte(ptr_lo_addr);
  assign ptr_hi_data = mem_byte(ptr_hi_addr);

  ea_gen u_ea_gen (
    .mode(mode), .pc(pc), .opnd_lo(opnd_lo), .opnd_hi(opnd_hi),
    .idx_x(idx_x), .idx_y(idx_y), .ptr_lo_addr(ptr_lo_addr),
    .ptr_hi_addr(ptr_hi_addr), .ptr_lo_data(ptr_lo_data),
    .ptr_hi_data(ptr_hi_data), .ea(ea), .page_cross(page_cross)
  );

  function automatic string req_of(input int m);
    case (m)
      0, 1:   return "R1";
      2:      return "R2";
      3:      return "R3";
      4, 5:   return "R4";
      6:      return "R5";
      7, 8:   return "R6";
      9:      return "R7";
      10:     return "R8";
      11:     return "R9";
      12:     return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check_now();
    int m, lo, hi, b, e, pl, ph, off;
    bit pcx, chk_ptr;
    string r;
    m = int'(mode); lo = int'(opnd_lo); hi = int'(opnd_hi);
    e = 0; pcx = 0; chk_ptr = 0; pl = 0; ph = 0;
    case (m)
      2: e = (int'(pc) + 1) % 65536;
      3: e = lo;
      4: e = (lo + int'(idx_x)) % 256;
      5: e = (lo + int'(idx_y)) % 256;
      6: e = hi * 256 + lo;
      7, 8: begin
        b = hi * 256 + lo;
        e = (b + ((m == 7) ? int'(idx_x) : int'(idx_y))) % 65536;
        pcx = (e / 256) != hi;
      end
      9: begin
        pl = (lo + int'(idx_x)) % 256; ph = (pl + 1) % 256; chk_ptr = 1;
        e = int'(mem_byte(16'(ph))) * 256 + int'(mem_byte(16'(pl)));
      end
      10: begin
        pl = lo; ph = (lo + 1) % 256; chk_ptr = 1;
        b = int'(mem_byte(16'(ph))) * 256 + int'(mem_byte(16'(pl)));
        e = (b + int'(idx_y)) % 65536;
        pcx = (e / 256) != (b / 256);
      end
      11: begin
        pl = hi * 256 + lo; ph = hi * 256 + (lo + 1) % 256; chk_ptr = 1;
        e = int'(mem_byte(16'(ph))) * 256 + int'(mem_byte(16'(pl)));
      end
      12: begin
        off = (lo < 128) ? lo : lo - 256;
        e = (int'(pc) + 2 + off + 65536) % 65536;
      end
      default: e = 0;
    endcase
    r = req_of(m);
    checks++;
    if (int'(ea) != e) begin
      errors++;
      $display("FAIL %s mode %0d ea actual %h expected %h", r, m, ea, 16'(e));
    end
    checks++;
    if (page_cross != pcx) begin
      errors++;
      $display("FAIL %s mode %0d page_cross actual %0b expected %0b", r, m, page_cross, pcx);
    end
    if (chk_ptr) begin
      checks++;
      if (int'(ptr_lo_addr) != pl || int'(ptr_hi_addr) != ph) begin
        errors++;
        $display("FAIL %s mode %0d ptr actual %h/%h expected %h/%h", r, m,
                 ptr_lo_addr, ptr_hi_addr, 16'(pl), 16'(ph));
      end
    end
  endtask

  task automatic apply(input int m, input int p, input int lo, input int hi,
                       input int x, input int y);
    @(posedge clk);
    #1;
    mode = 4'(m); pc = 16'(p); opnd_lo = 8'(lo); opnd_hi = 8'(hi);
    idx_x = 8'(x); idx_y = 8'(y);
    @(negedge clk);
    check_now();
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_now();                                 // R1 start-up state, implied mode
    apply(1, 'h1234, 'h55, 'h66, 1, 2);          // R1 accumulator
    apply(2, 'h8000, 0, 0, 0, 0);                // R2
    apply(2, 'hFFFF, 0, 0, 0, 0);                // R2 wrap to 0x0000
    apply(3, 'h1000, 'hAB, 'hCD, 0, 0);          // R3
    apply(4, 0, 'hF0, 0, 'h20, 0);               // R4 wraps to 0x0010
    apply(5, 0, 'h10, 'h77, 0, 'h05);            // R4 Y index
    apply(6, 0, 'h34, 'h12, 9, 9);               // R5
    apply(7, 0, 'hF0, 'h12, 'h20, 0);            // R6 crosses page
    apply(7, 0, 'h00, 'h12, 'h05, 0);            // R6 no crossing
    apply(8, 0, 'hFF, 'hFF, 0, 1);               // R6 wraps to 0x0000
    apply(9, 0, 'hFE, 'h44, 1, 0);               // R7 pointer at 0xFF/0x00
    apply(9, 0, 'h20, 0, 4, 0);                  // R7
    apply(10, 0, 'hFF, 0, 0, 'h80);              // R8 pointer wraps in page zero
    apply(10, 0, 'h40, 0, 0, 'hFF);              // R8
    apply(11, 0, 'hFF, 'h30, 0, 0);              // R9 high byte from 0x3000
    apply(11, 0, 'h10, 'h30, 0, 0);              // R9
    apply(12, 'h1000, 'h80, 0, 0, 0);            // R10 most negative
    apply(12, 'h1000, 'h7F, 0, 0, 0);            // R10 most positive
    apply(12, 'h0000, 'hF0, 0, 0, 0);            // R10 wraps below zero
    apply(12, 'hFFFE, 'h01, 0, 0, 0);            // R10 wraps above top
    for (int m = 13; m < 16; m++) apply(m, 'h4321, 'hFF, 'hFF, 'hFF, 'hFF); // R11
    for (int i = 0; i < 2000; i++)
      apply(int'($urandom_range(0, 15)), int'($urandom_range(0, 65535)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
            int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule